// File: doc/BRIEF.md
# Paired Set/Clear Register Bank

This block is a byte-wide register file for a peripheral's control and interrupt-configuration bytes. A serial-bus front end sits in front of it and supplies a register index, a write strobe with a data byte, and a read strobe. The block returns the read byte, or an acknowledge/refuse verdict for a write, one cycle after the strobe. After each access it steps its own index forward, so a burst on the bus walks through consecutive locations.

Every writable register sits behind two neighbouring addresses. At the even address of the pair, each one in the written byte sets the stored bit. At the odd address, each one clears it. Zero bits change nothing at either address. Six fixed identification bytes and a live view of the interrupt source lines are also decoded. Holes in the map refuse writes and leave the index where it was, so the bus controller can report the refusal without losing its place.

Top module: `scbank`

## Requirements
- R1: Reads of 00h, 01h, 02h, 03h, 14h and 15h return 6Ah, 0Bh, 01h, 33h, 77h and 41h.
- R2: A write to an identification address (00h–03h, 14h, 15h) is acknowledged, and the byte read back there afterwards is unchanged.
- R3: There are seven stored registers, at the address pairs 04h/05h, 06h/07h, 0Ah/0Bh, 0Ch/0Dh, 0Eh/0Fh, 12h/13h and 16h/17h. A write to the even address of a pair ORs the data into the stored byte.
- R4: A write to the odd address of a pair clears each stored bit whose data bit is one. Bits written as zero are left unchanged.
- R5: A read of either address of a pair returns the stored byte.
- R6: A read of 08h returns irq_src as sampled at the read strobe's clock edge. A write to 08h is acknowledged and stores nothing.
- R7: Addresses 09h, 10h, 11h and 18h–FFh are unused. A write there answers ack_ok=0, leaves the index unchanged and alters no register. A read there returns 00h.
- R8: The index increments by one after every acknowledged write and after every read, and wraps from FFh to 00h.
- R9: idx_ld loads idx_in into the index in one cycle. A write or read strobe in the same cycle is ignored.
- R10: rd_data and the ack_vld/ack_ok pair are registered and appear on the cycle after the strobe. ack_vld is high for exactly one cycle per write. If wr_en and rd_en are both high, only the write is performed.
- R11: A synchronous active-high reset clears the stored registers, the index, rd_data, ack_vld and ack_ok to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| idx_ld | input | 1 | Load idx_in into the register index |
| idx_in | input | 8 | Index value to load |
| wr_en | input | 1 | Write strobe at the current index |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe at the current index |
| irq_src | input | 8 | Live interrupt source lines, visible at 08h |
| rd_data | output | 8 | Registered read byte |
| ack_vld | output | 1 | One-cycle pulse after each write |
| ack_ok | output | 1 | 1 = acknowledged, 0 = refused (valid with ack_vld) |
| idx_o | output | 8 | Current register index |

## Verification
The bench sweeps all 256 indices three times: once reading from reset, once writing a distinct pattern at every address, and once reading back against a model of the set/clear rules. These sweeps catch a hole that is wrongly acknowledged, or that moves the index and so throws the bus out of step. They also catch a set/clear pair with its halves swapped, which would clear where it should set. Targeted cases cover the following:
- the FFh-to-00h wrap, where a design stuck at FFh would re-read the same byte;
- both addresses of a pair reading the same byte;
- a simultaneous write and read, where a design honouring the read would also skip the write;
- a reset in mid-state, after which stale bits would remain.

// File: rtl/scbank.sv
module scbank #(
  parameter logic [7:0] ID0 = 8'h6A,
  parameter logic [7:0] ID1 = 8'h0B,
  parameter logic [7:0] ID2 = 8'h01,
  parameter logic [7:0] ID3 = 8'h33,
  parameter logic [7:0] ID4 = 8'h77,
  parameter logic [7:0] ID5 = 8'h41
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       idx_ld,
  input  logic [7:0] idx_in,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [7:0] irq_src,
  output logic [7:0] rd_data,
  output logic       ack_vld,
  output logic       ack_ok,
  output logic [7:0] idx_o
);
  localparam int NREG = 7;
  localparam int PW   = $clog2(NREG);

  logic [7:0]    idx;
  logic [7:0]    bank [NREG];
  logic          hit;
  logic [PW-1:0] slot;
  logic          hole;
  logic [7:0]    rmux;

  always_comb begin
    hit  = 1'b1;
    slot = '0;
    case (idx[7:1])
      7'h02:   slot = PW'(0);
      7'h03:   slot = PW'(1);
      7'h05:   slot = PW'(2);
      7'h06:   slot = PW'(3);
      7'h07:   slot = PW'(4);
      7'h09:   slot = PW'(5);
      7'h0B:   slot = PW'(6);
      default: hit = 1'b0;
    endcase
  end

  assign hole = (idx == 8'h09) || (idx == 8'h10) || (idx == 8'h11) || (idx >= 8'h18);

  always_comb begin
    rmux = 8'h00;
    if (hit) rmux = bank[slot];
    else
      case (idx)
        8'h00: rmux = ID0;
        8'h01: rmux = ID1;
        8'h02: rmux = ID2;
        8'h03: rmux = ID3;
        8'h08: rmux = irq_src;
        8'h14: rmux = ID4;
        8'h15: rmux = ID5;
        default: rmux = 8'h00;
      endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx     <= '0;
      rd_data <= '0;
      ack_vld <= 1'b0;
      ack_ok  <= 1'b0;
      for (int i = 0; i < NREG; i++) bank[i] <= '0;
    end else begin
      ack_vld <= 1'b0;
      ack_ok  <= 1'b0;
      if (idx_ld) begin
        idx <= idx_in;
      end else if (wr_en) begin
        ack_vld <= 1'b1;
        ack_ok  <= !hole;
        if (!hole) idx <= idx + 8'd1;
        if (hit) bank[slot] <= idx[0] ? (bank[slot] & ~wr_data) : (bank[slot] | wr_data);
      end else if (rd_en) begin
        rd_data <= rmux;
        idx     <= idx + 8'd1;
      end
    end
  end

  assign idx_o = idx;
endmodule

// File: rtl/scbank_chk.sv
module scbank_chk (
  input logic       clk,
  input logic       rst,
  input logic       idx_ld,
  input logic       wr_en,
  input logic       rd_en,
  input logic       ack_vld,
  input logic       ack_ok,
  input logic [7:0] idx_o
);
  a_r7_refuse_holds_index: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && !ack_ok) |-> (idx_o == $past(idx_o)));

  a_r8_ack_steps_index: assert property (@(posedge clk) disable iff (rst)
    (ack_vld && ack_ok) |-> (idx_o == $past(idx_o) + 8'd1));

  a_r8_read_steps_index: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && rd_en && !wr_en && !idx_ld)) |-> (idx_o == $past(idx_o) + 8'd1));

  a_r10_ack_after_write: assert property (@(posedge clk) disable iff (rst)
    ack_vld |-> $past(wr_en && !idx_ld));

  a_r10_ok_needs_valid: assert property (@(posedge clk) disable iff (rst)
    ack_ok |-> ack_vld);

  a_r11_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (idx_o == 8'h00 && !ack_vld));
endmodule

bind scbank scbank_chk chk (
  .clk(clk), .rst(rst), .idx_ld(idx_ld), .wr_en(wr_en), .rd_en(rd_en),
  .ack_vld(ack_vld), .ack_ok(ack_ok), .idx_o(idx_o)
);

// File: tb/scbank_test.sv
module scbank_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       idx_ld = 1'b0;
  logic [7:0] idx_in = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] irq_src = 8'hA5;
  logic [7:0] rd_data;
  logic       ack_vld, ack_ok;
  logic [7:0] idx_o;

  int checks = 0;
  int errors = 0;
  logic [7:0] mdl [7];

  always #4 clk = ~clk;

  scbank uut (.*);

  function automatic int pair_of(input logic [7:0] a);
    case (a[7:1])
      7'h02: return 0; 7'h03: return 1; 7'h05: return 2; 7'h06: return 3;
      7'h07: return 4; 7'h09: return 5; 7'h0B: return 6;
      default: return -1;
    endcase
  endfunction

  function automatic bit unused(input logic [7:0] a);
    return a == 8'h09 || a == 8'h10 || a == 8'h11 || a >= 8'h18;
  endfunction

  function automatic logic [7:0] expect_rd(input logic [7:0] a);
    int p = pair_of(a);
    if (p >= 0) return mdl[p];
    case (a)
      8'h00: return 8'h6A; 8'h01: return 8'h0B; 8'h02: return 8'h01;
      8'h03: return 8'h33; 8'h14: return 8'h77; 8'h15: return 8'h41;
      8'h08: return irq_src;
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic load(input logic [7:0] a);
    @(negedge clk); idx_ld = 1'b1; idx_in = a;
    @(negedge clk); idx_ld = 1'b0;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic model_wr(input logic [7:0] a, input logic [7:0] d);
    int p = pair_of(a);
    if (p >= 0) mdl[p] = a[0] ? (mdl[p] & ~d) : (mdl[p] | d);
  endtask

  task automatic read_sweep(input string tag);
    load(8'h00);
    for (int a = 0; a < 256; a++) begin
      rd();
      check({tag, " R1/R5/R6/R7 read"}, rd_data, expect_rd(8'(a)));
      check("R8 read index step", idx_o, 8'(a + 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) mdl[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R11 reset index", idx_o, 8'h00);
    check("R11 reset rd_data", rd_data, 8'h00);
    check("R11 reset ack", {7'b0, ack_vld | ack_ok}, 8'h00);

    read_sweep("sweep0");
    check("R8 wrap to 00", idx_o, 8'h00);

    for (int a = 0; a < 256; a++) begin
      logic [7:0] d = 8'(a) ^ 8'h5C;
      load(8'(a));
      check("R9 index load", idx_o, 8'(a));
      wr(d);
      check("R10 ack valid", {7'b0, ack_vld}, 8'h01);
      check("R7 ack verdict", {7'b0, ack_ok}, unused(8'(a)) ? 8'h00 : 8'h01);
      check("R7/R8 index after write", idx_o, unused(8'(a)) ? 8'(a) : 8'(a + 1));
      model_wr(8'(a), d);
      @(negedge clk);
      check("R10 ack one cycle", {7'b0, ack_vld}, 8'h00);
    end
    read_sweep("sweep1 R2 R3 R4");

    load(8'h04); wr(8'hFF); model_wr(8'h04, 8'hFF);
    wr(8'h0F); model_wr(8'h05, 8'h0F);
    load(8'h04); rd(); check("R3/R4 set then clear via 04h", rd_data, 8'hF0);
    rd(); check("R5 read odd address of pair", rd_data, 8'hF0);
    load(8'h16); wr(8'h00); wr(8'h00);
    load(8'h16); rd(); check("R4 zero bits no effect", rd_data, mdl[6]);

    irq_src = 8'h3C;
    load(8'h08); rd(); check("R6 live source view", rd_data, 8'h3C);
    load(8'h08); wr(8'hFF);
    check("R6 write to 08h acked", {7'b0, ack_ok}, 8'h01);
    load(8'h08); rd(); check("R6 write ignored", rd_data, 8'h3C);

    load(8'hFF); rd(); check("R8 wrap from FF", idx_o, 8'h00);
    check("R7 unused read zero", rd_data, 8'h00);

    load(8'h0C);
    @(negedge clk); wr_en = 1'b1; rd_en = 1'b1; wr_data = 8'h81;
    @(negedge clk); wr_en = 1'b0; rd_en = 1'b0;
    model_wr(8'h0C, 8'h81);
    check("R10 write wins over read", {7'b0, ack_vld}, 8'h01);
    check("R10 index once", idx_o, 8'h0D);
    load(8'h0C); rd(); check("R10 write applied", rd_data, mdl[3]);

    load(8'h20);
    @(negedge clk); idx_ld = 1'b1; idx_in = 8'h06; wr_en = 1'b1; wr_data = 8'hFF;
    @(negedge clk); idx_ld = 1'b0; wr_en = 1'b0;
    check("R9 strobe ignored on load", {7'b0, ack_vld}, 8'h00);
    rd(); check("R9 load-cycle write dropped", rd_data, mdl[1]);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 7; i++) mdl[i] = 8'h00;
    check("R11 reset index mid-run", idx_o, 8'h00);
    read_sweep("sweep2 R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule